// File: doc/BRIEF.md
# Snoop-Priority Tag Port Arbiter

This block decides, every clock cycle, which of three contenders owns a single-ported cache tag array: a pending tag write, a coherency snoop lookup, or a load/store lookup. Only one of them can use the port in a given cycle. A tag write always keeps the port, so it is never cut short. When no write is pending, a snoop wins over a load/store. A snoop that arrives in the same cycle as a tag write is not served. Instead it receives a one-cycle retry pulse, and the snoop side must raise its request again later.

Load/store lookups enter through a valid/ready stream. The arbiter accepts a request whenever `ls_ready` is high, and `ls_ready` is high exactly when the one-entry hold slot is empty. An accepted lookup that loses arbitration is parked in the hold slot. It is replayed in the first later cycle that has neither a snoop nor a tag write. While the slot is occupied, `ls_ready` is low. The upstream source must then keep its request and payload stable, and nothing is taken from it. The snoop and tag-write inputs are plain per-cycle levels with no back-pressure. The port owner and the address it drives appear on `port_op` and `port_addr` in the same cycle as the decision.

Top module: `tag_snoop_arb`

## Requirements
- R1: After reset the hold slot is empty: `ls_deferred` is 0 and `ls_ready` is 1.
- R2: In every cycle at most one of `ls_grant`, `snp_grant`, `tw_grant` is high. `port_op` names the owner with these codes: 0 idle, 1 load, 2 store, 3 snoop, 4 tag write.
- R3: A snoop with no tag write pending is granted in the same cycle. In that cycle `port_op` is 3 and `port_addr` equals `snp_addr`.
- R4: A snoop in a cycle with a tag write pending is not granted, and `snp_retry` is high for that cycle only. `snp_retry` is never high in any other cycle.
- R5: A pending tag write is always granted, with `port_op` 4 and `port_addr` equal to `tw_addr`, whatever the other requests are.
- R6: A load/store accepted (`ls_valid` and `ls_ready`) that is not granted in the same cycle is held. From the next cycle `ls_deferred` is 1 and `ls_ready` is 0 until the held access is granted.
- R7: A held access is granted in the first cycle with neither a snoop nor a tag write, however many snoops came before it. It is granted with its original address and load/store kind, and a new `ls_valid` offered while it is held has no effect on the port.
- R8: An accepted load/store with no snoop and no write pending is granted in the same cycle, with `port_op` 1 for a load or 2 for a store (`ls_store` = 1) and `port_addr` equal to `ls_addr`.
- R9: In a cycle with no contender, no grant is high, `port_op` is 0 and `port_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_valid | input | 1 | Load/store lookup offered |
| ls_ready | output | 1 | Hold slot free; lookup accepted this cycle |
| ls_addr | input | ADDR_W | Load/store tag index |
| ls_store | input | 1 | 1 = store, 0 = load |
| snp_req | input | 1 | Snoop lookup request (level, this cycle) |
| snp_addr | input | ADDR_W | Snoop tag index |
| tw_pend | input | 1 | Tag write occupies the port this cycle |
| tw_addr | input | ADDR_W | Tag write index |
| ls_grant | output | 1 | Load/store owns the port |
| snp_grant | output | 1 | Snoop owns the port |
| tw_grant | output | 1 | Tag write owns the port |
| snp_retry | output | 1 | Snoop collided with a tag write; request again |
| ls_deferred | output | 1 | A lost load/store waits in the hold slot |
| port_op | output | 3 | Port owner code (R2) |
| port_addr | output | ADDR_W | Index driven to the tag array |

## Verification
The grants, retry pulse, `port_op` and `port_addr` respond to the inputs in the same cycle, because they are decided combinationally from the inputs and the hold slot. `ls_deferred` and `ls_ready` change one clock edge after a lookup loses or is replayed. The bench drives inputs on the falling edge and compares every output a quarter period later, before the next rising edge. After each comparison it advances its own hold-slot model, so a deferral shows up one cycle after the stimulus that caused it. Every three-cycle sequence of the eight request combinations is swept. Directed runs of one to six back-to-back snoops confirm that the replay lands exactly in the first free cycle.

// File: rtl/tag_arb_pkg.sv
package tag_arb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_SNOOP = 3'd3,
    OP_WRITE = 3'd4
  } tag_op_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LS   = 2'd1,
    OWN_SNP  = 2'd2,
    OWN_WR   = 2'd3
  } owner_e;
endpackage

// File: rtl/tas_hold_slot.sv
module tas_hold_slot #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_store,
  input  logic              granted,
  output logic              held,
  output logic              cand_vld,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              cand_store
);
  logic [ADDR_W-1:0] hold_addr_q;
  logic              hold_store_q;
  logic              hold_vld_q;

  // held entry takes precedence; new input is only accepted while empty
  assign held       = hold_vld_q;
  assign cand_vld   = hold_vld_q | in_vld;
  assign cand_addr  = hold_vld_q ? hold_addr_q  : in_addr;
  assign cand_store = hold_vld_q ? hold_store_q : in_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld_q   <= 1'b0;
      hold_addr_q  <= '0;
      hold_store_q <= 1'b0;
    end else begin
      hold_vld_q <= cand_vld & ~granted;
      if (cand_vld & ~granted) begin
        hold_addr_q  <= cand_addr;
        hold_store_q <= cand_store;
      end
    end
  end
endmodule

// File: rtl/tas_prio_pick.sv
module tas_prio_pick
  import tag_arb_pkg::*;
(
  input  logic   cand_vld,
  input  logic   snp_req,
  input  logic   tw_pend,
  output owner_e owner,
  output logic   retry
);
  always_comb begin
    owner = OWN_NONE;
    retry = 1'b0;
    if (tw_pend) begin
      owner = OWN_WR;
      retry = snp_req;
    end else if (snp_req) begin
      owner = OWN_SNP;
    end else if (cand_vld) begin
      owner = OWN_LS;
    end
  end
endmodule

// File: rtl/tas_port_mux.sv
module tas_port_mux
  import tag_arb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  owner_e            owner,
  input  logic [ADDR_W-1:0] ls_addr,
  input  logic              ls_store,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0] tw_addr,
  output tag_op_e           op,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    unique case (owner)
      OWN_WR:  begin op = OP_WRITE; addr = tw_addr;  end
      OWN_SNP: begin op = OP_SNOOP; addr = snp_addr; end
      OWN_LS:  begin op = ls_store ? OP_STORE : OP_LOAD; addr = ls_addr; end
      default: begin op = OP_IDLE;  addr = '0;       end
    endcase
  end
endmodule

// File: rtl/tag_snoop_arb.sv
module tag_snoop_arb
  import tag_arb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ls_valid,
  output logic              ls_ready,
  input  logic [ADDR_W-1:0] ls_addr,
  input  logic              ls_store,
  input  logic              snp_req,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              tw_pend,
  input  logic [ADDR_W-1:0] tw_addr,
  output logic              ls_grant,
  output logic              snp_grant,
  output logic              tw_grant,
  output logic              snp_retry,
  output logic              ls_deferred,
  output logic [2:0]        port_op,
  output logic [ADDR_W-1:0] port_addr
);
  logic              held;
  logic              cand_vld;
  logic [ADDR_W-1:0] cand_addr;
  logic              cand_store;
  owner_e            owner;
  tag_op_e           op;

  assign ls_ready = ~held;

  tas_hold_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (ls_valid),
    .in_addr    (ls_addr),
    .in_store   (ls_store),
    .granted    (ls_grant),
    .held       (held),
    .cand_vld   (cand_vld),
    .cand_addr  (cand_addr),
    .cand_store (cand_store)
  );

  tas_prio_pick u_pick (
    .cand_vld (cand_vld),
    .snp_req  (snp_req),
    .tw_pend  (tw_pend),
    .owner    (owner),
    .retry    (snp_retry)
  );

  tas_port_mux #(.ADDR_W(ADDR_W)) u_mux (
    .owner    (owner),
    .ls_addr  (cand_addr),
    .ls_store (cand_store),
    .snp_addr (snp_addr),
    .tw_addr  (tw_addr),
    .op       (op),
    .addr     (port_addr)
  );

  assign ls_grant    = (owner == OWN_LS);
  assign snp_grant   = (owner == OWN_SNP);
  assign tw_grant    = (owner == OWN_WR);
  assign ls_deferred = held;
  assign port_op     = op;
endmodule

// File: rtl/tag_snoop_arb_chk.sv
module tag_snoop_arb_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ls_valid,
  input logic              ls_ready,
  input logic              snp_req,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              tw_pend,
  input logic [ADDR_W-1:0] tw_addr,
  input logic              ls_grant,
  input logic              snp_grant,
  input logic              tw_grant,
  input logic              snp_retry,
  input logic              ls_deferred,
  input logic [2:0]        port_op,
  input logic [ADDR_W-1:0] port_addr
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ls_grant, snp_grant, tw_grant}) <= 1); // R2
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && !tw_pend) |-> (snp_grant && port_addr == snp_addr)); // R3
  AST_RETRY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && tw_pend) |-> (snp_retry && !snp_grant)); // R4
  AST_RETRY_ONLY_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> (tw_grant && snp_req)); // R4
  AST_WRITE_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    tw_pend |-> (tw_grant && port_op == 3'd4 && port_addr == tw_addr)); // R5
  AST_LOSER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_valid && ls_ready && !ls_grant) |=> ls_deferred); // R6
  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_deferred && !ls_grant) |=> ls_deferred); // R6
  AST_HELD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ls_deferred |-> !ls_ready); // R6
  AST_REPLAY_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_deferred && !snp_req && !tw_pend) |-> ls_grant); // R7
  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_grant && !snp_grant && !tw_grant) |-> (port_op == 3'd0)); // R9
endmodule

bind tag_snoop_arb tag_snoop_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ls_valid    (ls_valid),
  .ls_ready    (ls_ready),
  .snp_req     (snp_req),
  .snp_addr    (snp_addr),
  .tw_pend     (tw_pend),
  .tw_addr     (tw_addr),
  .ls_grant    (ls_grant),
  .snp_grant   (snp_grant),
  .tw_grant    (tw_grant),
  .snp_retry   (snp_retry),
  .ls_deferred (ls_deferred),
  .port_op     (port_op),
  .port_addr   (port_addr)
);

// File: tb/tag_snoop_arb_bench.sv
module tag_snoop_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls_valid = 0, ls_store = 0, snp_req = 0, tw_pend = 0;
  logic [AW-1:0] ls_addr = '0, snp_addr = '0, tw_addr = '0;
  logic ls_ready, ls_grant, snp_grant, tw_grant, snp_retry, ls_deferred;
  logic [2:0] port_op;
  logic [AW-1:0] port_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model of the hold slot
  bit m_vld = 0;
  int m_addr = 0;
  bit m_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_snoop_arb #(.ADDR_W(AW)) u_tag_snoop_arb (
    .clk(clk), .rst_n(rst_n),
    .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_addr(ls_addr), .ls_store(ls_store),
    .snp_req(snp_req), .snp_addr(snp_addr), .tw_pend(tw_pend), .tw_addr(tw_addr),
    .ls_grant(ls_grant), .snp_grant(snp_grant), .tw_grant(tw_grant),
    .snp_retry(snp_retry), .ls_deferred(ls_deferred),
    .port_op(port_op), .port_addr(port_addr)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, compare a quarter period later, advance model
  task automatic step(input bit lv, input int la, input bit ls, input bit sv,
                      input int sa, input bit wv, input int wa);
    bit cand, cst, g_ls;
    int ca, e_op, e_addr;
    @(negedge clk);
    ls_valid = lv; ls_addr = AW'(la); ls_store = ls;
    snp_req = sv; snp_addr = AW'(sa); tw_pend = wv; tw_addr = AW'(wa);
    #(CLK_PERIOD/4);
    cand = m_vld || lv;
    ca   = m_vld ? m_addr : (la % (1 << AW));
    cst  = m_vld ? m_st : ls;
    g_ls = cand && !sv && !wv;
    if (wv)        begin e_op = 4; e_addr = wa % (1 << AW); end
    else if (sv)   begin e_op = 3; e_addr = sa % (1 << AW); end
    else if (g_ls) begin e_op = cst ? 2 : 1; e_addr = ca; end
    else           begin e_op = 0; e_addr = 0; end
    cmp("R1/R6", "ls_ready", int'(ls_ready), int'(!m_vld));
    cmp("R6", "ls_deferred", int'(ls_deferred), int'(m_vld));
    cmp("R5", "tw_grant", int'(tw_grant), int'(wv));
    cmp("R3", "snp_grant", int'(snp_grant), int'(sv && !wv));
    cmp("R4", "snp_retry", int'(snp_retry), int'(sv && wv));
    cmp(m_vld ? "R7" : "R8", "ls_grant", int'(ls_grant), int'(g_ls));
    cmp("R2", "grant count", int'(ls_grant) + int'(snp_grant) + int'(tw_grant),
        int'(wv || sv || cand));
    cmp(e_op == 0 ? "R9" : "R2", "port_op", int'(port_op), e_op);
    cmp(m_vld ? "R7" : "R3/R5/R8", "port_addr", int'(port_addr), e_addr);
    if (cand && !g_ls) begin
      m_vld = 1; m_addr = ca; m_st = cst;
    end else begin
      m_vld = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("R1", "ls_deferred in reset", int'(ls_deferred), 0);
    cmp("R1", "ls_ready in reset", int'(ls_ready), 1);
    rst_n = 1'b1;
    tag = 1;
    // sweep every 3-cycle sequence of (ls, snoop, write) combinations
    for (int s = 0; s < 512; s++) begin
      for (int c = 0; c < 3; c++) begin
        int code;
        code = (s >> (3 * c)) & 7;
        tag = tag + 5;
        step(code[0], tag, tag[1], code[1], tag + 1, code[2], tag + 2);
      end
      // drain: a free cycle with a new offer that R7 says must be ignored if held
      tag = tag + 3;
      step(1'b1, tag, 1'b0, 1'b0, 0, 1'b0, 0);
      step(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0);
    end
    // R7: back-to-back snoops keep deferring; replay in first free cycle
    for (int k = 1; k <= 6; k++) begin
      step(1'b1, 40 + k, k[0], 1'b1, 7, 1'b0, 0);
      for (int j = 1; j < k; j++) step(1'b1, 9, 1'b0, 1'b1, 8 + j, j[0], 3);
      step(1'b1, 11, 1'b0, 1'b0, 0, 1'b0, 0);
      cmp("R7", "replay done", int'(m_vld), 0);
      step(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule